// File: doc/BRIEF.md
# Dual-Match Dual-Capture Timer Channel

This block is one timer input/output channel. It holds two match registers and two capture registers, each 24 bits wide by default. Each register follows one of two shared timebase buses, chosen per register. A match fires when its selected bus equals its stored value while the match is armed. The firing match then applies a programmed action to the output pin. Input edges on the sampled pin latch the selected bus into the capture registers. Every match or capture event raises a sticky service-request flag for a host or sequencer.

A 4-bit mode field chains the four registers together. In the basic mode the matches and captures work independently. In the windowed mode a capture is only accepted between match 0 and match 1. In the match-blocking mode match 1 cancels a pending match 0. In the edge-blocking mode an input edge cancels both pending matches. In the output-disable mode an edge outside the match window turns the output drive off. The two captures take consecutive edges, so a pulse one timebase count wide can be measured. Two matches on adjacent counts generate a pulse of the same width.

Top module: `evt_chan`

## Requirements
- R1: After reset, pin_out equals the PIN_INIT parameter (default 0), pin_oe is 1, all four flags are 0 and both capture values are 0.
- R2: Loading a match (ld_m bit i with ld_val) arms it. An armed match fires on the clock edge where its selected bus equals its value. It then disarms and does not fire again until it is reloaded. The action code acts on the pin after that edge: 0 leaves it, 1 drives high, 2 drives low, 3 toggles. When both matches fire on one edge, the action of match 1 is applied after that of match 0.
- R3: cfg_bus_sel bit 0 selects the bus for match 0, bit 1 for match 1, bit 2 for capture 0 and bit 3 for capture 1. A 0 in a bit selects tb_a and a 1 selects tb_b. A value that appears only on the unselected bus does nothing.
- R4: cfg_edge selects the qualifying edges: 0 none, 1 rising, 2 falling, 3 either. A qualifying edge latches the selected bus value, as it stands on the clock edge where the new pin level is first sampled. The edge goes to capture 0 while flag bit 2 is clear. It goes to capture 1 while flag bit 2 is set and flag bit 3 is clear. It is dropped when both flags are set.
- R5: The flag bits are 0 match 0, 1 match 1, 2 capture 0 and 3 capture 1. Each event sets its bit. A 1 on the same bit of flg_clr clears it, and a set on the same edge wins over the clear.
- R6: Mode 1 (window) accepts a capture only while the window is open. The window opens after the edge on which match 0 fires. It closes after the edge on which match 1 fires, and an edge sampled together with match 1 still counts.
- R7: Mode 2 (match blocking): when match 1 fires, a pending match 0 is cancelled. This also holds on an edge where both would fire, and then only match 1 fires.
- R8: Mode 3 (edge blocking): a qualifying input edge cancels both pending matches, including any match that would fire on that same clock edge. The edge is still captured.
- R9: Mode 4 (output disable): captures are windowed as in mode 1. A qualifying edge while the window is closed drives pin_oe to 0 after that clock edge. pin_oe returns to 1 after the next load of match 0.
- R10: Mode codes 5 to 15 behave exactly as mode 0. Matches do not block each other and captures are not windowed.
- R11: Match 0 with action 1 and match 1 with action 2, on consecutive bus counts, produce a high pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tb_a | input | TW | Timebase bus A |
| tb_b | input | TW | Timebase bus B |
| cfg_mode | input | 4 | Channel mode code |
| cfg_bus_sel | input | 4 | Per-register bus select (m0, m1, c0, c1) |
| cfg_act0 | input | 2 | Pin action of match 0 |
| cfg_act1 | input | 2 | Pin action of match 1 |
| cfg_edge | input | 2 | Capture edge select |
| ld_m | input | 2 | Load-and-arm strobe per match |
| ld_val | input | TW | Value written on a match load |
| flg_clr | input | 4 | Flag clear bits |
| pin_in | input | 1 | Input pin |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output drive enable |
| flg | output | 4 | Service-request flags |
| cap0_val | output | TW | Capture register 0 |
| cap1_val | output | TW | Capture register 1 |

## Verification
With the default direct pin sampling, every result appears one clock edge after its stimulus. This covers the pin level after a match, the flag set or clear, a latched capture value, and the change of pin_oe after an edge or a reload. The bench drives every input just after a falling edge and then steps across exactly one rising edge. It samples on the next falling edge, so each check sees the state produced by that single edge. The once-only firing of a match is checked one further edge later, with the bus still holding the matching value.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

   localparam int N_MATCH = 2;
   localparam int N_CAPT  = 2;

   typedef enum logic [3:0] {
      MD_BASIC  = 4'd0,
      MD_WINDOW = 4'd1,
      MD_MBLOCK = 4'd2,
      MD_EBLOCK = 4'd3,
      MD_ODIS   = 4'd4
   } chan_mode_e;

   localparam logic [1:0] ACT_NONE   = 2'd0;
   localparam logic [1:0] ACT_HIGH   = 2'd1;
   localparam logic [1:0] ACT_LOW    = 2'd2;
   localparam logic [1:0] ACT_TOGGLE = 2'd3;

   function automatic chan_mode_e decode_mode(input logic [3:0] code);
      if (code > 4'd4) return MD_BASIC;
      return chan_mode_e'(code);
   endfunction

   function automatic logic apply_act(input logic [1:0] act, input logic hit, input logic cur);
      logic r;
      r = cur;
      if (hit) begin
         case (act)
            ACT_HIGH:   r = 1'b1;
            ACT_LOW:    r = 1'b0;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/evt_match.sv
module evt_match #(
   parameter int TW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tb_a,
   input  logic [TW-1:0] tb_b,
   input  logic          bus_sel,
   input  logic          ld,
   input  logic [TW-1:0] ld_val,
   input  logic          fire,
   input  logic          kill,
   output logic          cand
);
   logic [TW-1:0] val_q;
   logic          armed_q;
   logic [TW-1:0] tb_pick;

   assign tb_pick = bus_sel ? tb_b : tb_a;
   assign cand    = armed_q && (tb_pick == val_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q   <= '0;
         armed_q <= 1'b0;
      end else if (ld) begin
         val_q   <= ld_val;
         armed_q <= 1'b1;
      end else if (fire || kill) begin
         armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/evt_capture.sv
module evt_capture #(
   parameter int TW      = 24,
   parameter bit SYNC_IN = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tb_a,
   input  logic [TW-1:0] tb_b,
   input  logic [1:0]    sel,
   input  logic [1:0]    edge_mode,
   input  logic          pin_in,
   input  logic          cap_ok,
   input  logic [1:0]    full,
   output logic          edge_hit,
   output logic [1:0]    take,
   output logic [TW-1:0] cap0,
   output logic [TW-1:0] cap1
);
   logic pin_s;
   logic pin_q;
   logic rise;
   logic fall;

   generate
      if (SYNC_IN) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], pin_in};
         end
         assign pin_s = sync_q[1];
      end else begin : g_direct
         assign pin_s = pin_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_s;
   end

   assign rise     = pin_s & ~pin_q;
   assign fall     = ~pin_s & pin_q;
   assign edge_hit = (edge_mode[0] & rise) | (edge_mode[1] & fall);
   assign take[0]  = cap_ok & ~full[0];
   assign take[1]  = cap_ok & full[0] & ~full[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap0 <= '0;
         cap1 <= '0;
      end else begin
         if (take[0]) cap0 <= sel[0] ? tb_b : tb_a;
         if (take[1]) cap1 <= sel[1] ? tb_b : tb_a;
      end
   end
endmodule

// File: rtl/evt_mode.sv
module evt_mode
   import evt_chan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode_code,
   input  logic [1:0] cand,
   input  logic       edge_hit,
   input  logic       rearm,
   output logic [1:0] fire,
   output logic [1:0] kill,
   output logic       cap_ok,
   output logic       oe
);
   chan_mode_e md;
   logic       win_q;
   logic       trip;

   assign md = decode_mode(mode_code);

   always_comb begin
      fire   = cand;
      kill   = 2'b00;
      cap_ok = edge_hit;
      trip   = 1'b0;
      case (md)
         MD_WINDOW: cap_ok = edge_hit & win_q;
         MD_MBLOCK: begin
            fire[0] = cand[0] & ~cand[1];
            kill[0] = cand[1];
         end
         MD_EBLOCK: begin
            fire = cand & ~{2{edge_hit}};
            kill = {2{edge_hit}};
         end
         MD_ODIS: begin
            cap_ok = edge_hit & win_q;
            trip   = edge_hit & ~win_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         oe    <= 1'b1;
      end else begin
         win_q <= (win_q | fire[0]) & ~fire[1];
         if (trip)       oe <= 1'b0;
         else if (rearm) oe <= 1'b1;
      end
   end
endmodule

// File: rtl/evt_chan.sv
module evt_chan
   import evt_chan_pkg::*;
#(
   parameter int TW       = 24,
   parameter bit PIN_INIT = 1'b0,
   parameter bit SYNC_IN  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] tb_a,
   input  logic [TW-1:0] tb_b,
   input  logic [3:0]    cfg_mode,
   input  logic [3:0]    cfg_bus_sel,
   input  logic [1:0]    cfg_act0,
   input  logic [1:0]    cfg_act1,
   input  logic [1:0]    cfg_edge,
   input  logic [1:0]    ld_m,
   input  logic [TW-1:0] ld_val,
   input  logic [3:0]    flg_clr,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          pin_oe,
   output logic [3:0]    flg,
   output logic [TW-1:0] cap0_val,
   output logic [TW-1:0] cap1_val
);
   localparam int N_FLG = N_MATCH + N_CAPT;

   generate
      if (TW < 2 || TW > 32) begin : g_bad_tw
         $error("evt_chan: TW must lie in 2..32");
      end
   endgenerate

   logic [N_MATCH-1:0] m_cand;
   logic [N_MATCH-1:0] m_fire;
   logic [N_MATCH-1:0] m_kill;
   logic [N_CAPT-1:0]  cap_take;
   logic               edge_hit;
   logic               cap_ok;
   logic [N_FLG-1:0]   flg_q;
   logic [N_FLG-1:0]   flg_set;
   logic               pin_q;

   for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_match
      evt_match #(.TW(TW)) u_match (
         .clk     (clk),
         .rst_n   (rst_n),
         .tb_a    (tb_a),
         .tb_b    (tb_b),
         .bus_sel (cfg_bus_sel[gi]),
         .ld      (ld_m[gi]),
         .ld_val  (ld_val),
         .fire    (m_fire[gi]),
         .kill    (m_kill[gi]),
         .cand    (m_cand[gi])
      );
   end

   evt_capture #(.TW(TW), .SYNC_IN(SYNC_IN)) u_capt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tb_a      (tb_a),
      .tb_b      (tb_b),
      .sel       (cfg_bus_sel[3:2]),
      .edge_mode (cfg_edge),
      .pin_in    (pin_in),
      .cap_ok    (cap_ok),
      .full      (flg_q[3:2]),
      .edge_hit  (edge_hit),
      .take      (cap_take),
      .cap0      (cap0_val),
      .cap1      (cap1_val)
   );

   evt_mode u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_code (cfg_mode),
      .cand      (m_cand),
      .edge_hit  (edge_hit),
      .rearm     (ld_m[0]),
      .fire      (m_fire),
      .kill      (m_kill),
      .cap_ok    (cap_ok),
      .oe        (pin_oe)
   );

   assign flg_set = {cap_take, m_fire};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_q <= '0;
         pin_q <= PIN_INIT;
      end else begin
         flg_q <= flg_set | (flg_q & ~flg_clr);
         pin_q <= apply_act(cfg_act1, m_fire[1], apply_act(cfg_act0, m_fire[0], pin_q));
      end
   end

   assign flg     = flg_q;
   assign pin_out = pin_q;
endmodule

// File: rtl/evt_chan_chk.sv
module evt_chan_chk #(
   parameter int TW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    cfg_mode,
   input logic [1:0]    ld_m,
   input logic [1:0]    m_fire,
   input logic          edge_hit,
   input logic [1:0]    cap_take,
   input logic [TW-1:0] cap0_val,
   input logic          pin_oe,
   input logic [3:0]    flg
);
   // R2
   fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_fire[0] && !ld_m[0]) |=> !m_fire[0]);

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_fire[1] |=> flg[1]);

   // R5
   cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_take[0] |=> flg[2]);

   // R4
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_take[0] |=> $stable(cap0_val));

   // R7
   mblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 4'd2 && m_fire[1]) |-> !m_fire[0]);

   // R8
   eblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 4'd3 && edge_hit) |-> (m_fire == 2'b00));

   // R9
   odis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_oe) |-> ($past(cfg_mode) == 4'd4));
endmodule

bind evt_chan evt_chan_chk #(.TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_mode (cfg_mode),
   .ld_m     (ld_m),
   .m_fire   (m_fire),
   .edge_hit (edge_hit),
   .cap_take (cap_take),
   .cap0_val (cap0_val),
   .pin_oe   (pin_oe),
   .flg      (flg)
);

// File: tb/evt_chan_test.sv
`timescale 1ns/1ps
module evt_chan_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] tb_a = '0, tb_b = '0, ld_val = '0;
   logic [3:0]  cfg_mode = '0, cfg_bus_sel = '0, flg_clr = '0;
   logic [1:0]  cfg_act0 = '0, cfg_act1 = '0, cfg_edge = '0, ld_m = '0;
   logic        pin_in = 1'b0;
   logic        pin_out, pin_oe;
   logic [3:0]  flg;
   logic [23:0] cap0_val, cap1_val;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #2 clk = ~clk;

   evt_chan uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tb_a = '0; tb_b = '0; ld_val = '0; cfg_mode = '0; cfg_bus_sel = '0;
      flg_clr = '0; cfg_act0 = '0; cfg_act1 = '0; cfg_edge = '0; ld_m = '0; pin_in = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic load(input int i, input int v);
      ld_m[i] = 1'b1; ld_val = 24'(v);
      step();
      ld_m = '0;
   endtask

   task automatic set_bus(input int a, input int b);
      tb_a = 24'(a); tb_b = 24'(b);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 pin_out", 32'(pin_out), 32'd0);
      chk("R1 pin_oe", 32'(pin_oe), 32'd1);
      chk("R1 flg", 32'(flg), 32'd0);
      chk("R1 cap0", 32'(cap0_val), 32'd0);
      chk("R1 cap1", 32'(cap1_val), 32'd0);

      // R2 R3 R5 sweep: match index, bus, action, starting pin level
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 2; s++)
            for (int a = 0; a < 4; a++)
               for (int p = 0; p < 2; p++) begin
                  logic expv;
                  do_reset();
                  cfg_bus_sel[m] = s[0];
                  if (p == 1) begin
                     if (m == 0) cfg_act1 = 2'd1; else cfg_act0 = 2'd1;
                     load(1 - m, 7);
                     set_bus(7, 7); step(); set_bus(0, 0);
                  end
                  if (m == 0) cfg_act0 = 2'(a); else cfg_act1 = 2'(a);
                  load(m, 1000);
                  if (s == 0) set_bus(0, 1000); else set_bus(1000, 0);
                  step();
                  chk("R3 unselected bus pin", 32'(pin_out), 32'(p));
                  chk("R3 unselected bus flag", 32'(flg[m]), 32'd0);
                  if (s == 0) set_bus(1000, 0); else set_bus(0, 1000);
                  step();
                  case (a)
                     0: expv = p[0];
                     1: expv = 1'b1;
                     2: expv = 1'b0;
                     default: expv = ~p[0];
                  endcase
                  chk("R2 action", 32'(pin_out), 32'(expv));
                  chk("R5 match flag", 32'(flg[m]), 32'd1);
                  step();
                  chk("R2 fires once", 32'(pin_out), 32'(expv));
                  flg_clr[m] = 1'b1; step(); flg_clr = '0;
                  chk("R5 flag clear", 32'(flg[m]), 32'd0);
               end

      // R4 capture edge select and bus select
      for (int e = 0; e < 4; e++)
         for (int s = 0; s < 2; s++) begin
            logic [23:0] v1, v2;
            do_reset();
            cfg_edge = 2'(e); cfg_bus_sel[2] = s[0];
            set_bus(11, 111); pin_in = 1'b1; step();
            v1 = (s == 1) ? 24'd111 : 24'd11;
            chk("R4 rise flag", 32'(flg[2]), 32'(e & 1));
            chk("R4 rise value", 32'(cap0_val), e[0] ? 32'(v1) : 32'd0);
            flg_clr = 4'b0100; step(); flg_clr = '0;
            set_bus(22, 122); pin_in = 1'b0; step();
            v2 = (s == 1) ? 24'd122 : 24'd22;
            chk("R4 fall flag", 32'(flg[2]), 32'((e >> 1) & 1));
            chk("R4 fall value", 32'(cap0_val),
                e[1] ? 32'(v2) : (e[0] ? 32'(v1) : 32'd0));
         end

      // R4 one-count pulse measured by the capture pair, third edge dropped
      do_reset();
      cfg_edge = 2'd3;
      set_bus(500, 0); pin_in = 1'b1; step();
      set_bus(501, 0); pin_in = 1'b0; step();
      chk("R4 narrow cap0", 32'(cap0_val), 32'd500);
      chk("R4 narrow cap1", 32'(cap1_val), 32'd501);
      chk("R4 narrow width", 32'(cap1_val - cap0_val), 32'd1);
      chk("R5 capture flags", 32'(flg[3:2]), 32'd3);
      set_bus(600, 0); pin_in = 1'b1; step();
      chk("R4 full drop cap0", 32'(cap0_val), 32'd500);
      chk("R4 full drop cap1", 32'(cap1_val), 32'd501);

      // R11 one-clock pulse generation
      do_reset();
      cfg_act0 = 2'd1; cfg_act1 = 2'd2;
      load(0, 10); load(1, 11);
      set_bus(10, 0); step();
      chk("R11 pulse high", 32'(pin_out), 32'd1);
      set_bus(11, 0); step();
      chk("R11 pulse low", 32'(pin_out), 32'd0);

      // R2 R7 same-edge firing in basic and match-blocking modes
      for (int k = 0; k < 2; k++) begin
         do_reset();
         cfg_mode = (k == 0) ? 4'd0 : 4'd2;
         cfg_act0 = 2'd1; cfg_act1 = 2'd0;
         load(0, 50); load(1, 50);
         set_bus(50, 0); step();
         if (k == 0) begin
            chk("R2 both fire flags", 32'(flg[1:0]), 32'd3);
            chk("R2 both fire pin", 32'(pin_out), 32'd1);
         end else begin
            chk("R7 same edge flags", 32'(flg[1:0]), 32'd2);
            chk("R7 same edge pin", 32'(pin_out), 32'd0);
         end
      end
      do_reset();
      cfg_act0 = 2'd1; cfg_act1 = 2'd2;
      load(0, 50); load(1, 50);
      set_bus(50, 0); step();
      chk("R2 match1 applied last", 32'(pin_out), 32'd0);

      // R7 blocked match versus R10 unused mode code
      for (int k = 0; k < 2; k++) begin
         do_reset();
         cfg_mode = (k == 0) ? 4'd2 : 4'd9;
         cfg_act0 = 2'd1; cfg_act1 = 2'd2;
         load(0, 40); load(1, 35);
         set_bus(35, 0); step();
         chk(k == 0 ? "R7 timeout flag" : "R10 timeout flag", 32'(flg[1]), 32'd1);
         set_bus(40, 0); step();
         if (k == 0) begin
            chk("R7 match0 cancelled flag", 32'(flg[0]), 32'd0);
            chk("R7 match0 cancelled pin", 32'(pin_out), 32'd0);
         end else begin
            chk("R10 match0 still fires flag", 32'(flg[0]), 32'd1);
            chk("R10 match0 still fires pin", 32'(pin_out), 32'd1);
         end
      end

      // R6 windowed capture
      do_reset();
      cfg_mode = 4'd1; cfg_edge = 2'd1;
      load(0, 20); load(1, 30);
      set_bus(5, 0); pin_in = 1'b1; step();
      chk("R6 edge before window", 32'(flg[2]), 32'd0);
      pin_in = 1'b0; step();
      set_bus(20, 0); step();
      set_bus(25, 0); pin_in = 1'b1; step();
      chk("R6 edge inside window flag", 32'(flg[2]), 32'd1);
      chk("R6 edge inside window value", 32'(cap0_val), 32'd25);
      pin_in = 1'b0; set_bus(30, 0); step();
      flg_clr = 4'b0100; step(); flg_clr = '0;
      set_bus(35, 0); pin_in = 1'b1; step();
      chk("R6 edge after window", 32'(flg[2]), 32'd0);
      chk("R6 value kept", 32'(cap0_val), 32'd25);

      // R8 edge blocking
      do_reset();
      cfg_mode = 4'd3; cfg_edge = 2'd3; cfg_act0 = 2'd1;
      load(0, 60); load(1, 62);
      set_bus(55, 0); pin_in = 1'b1; step();
      chk("R8 edge still captured", 32'(cap0_val), 32'd55);
      set_bus(60, 0); step();
      chk("R8 match0 cancelled flag", 32'(flg[0]), 32'd0);
      chk("R8 match0 cancelled pin", 32'(pin_out), 32'd0);
      set_bus(62, 0); step();
      chk("R8 match1 cancelled flag", 32'(flg[1]), 32'd0);

      // R9 output disable
      do_reset();
      cfg_mode = 4'd4; cfg_edge = 2'd1;
      load(0, 70); load(1, 80);
      chk("R9 drive on before fault", 32'(pin_oe), 32'd1);
      set_bus(65, 0); pin_in = 1'b1; step();
      chk("R9 early edge trips drive", 32'(pin_oe), 32'd0);
      chk("R9 early edge not captured", 32'(flg[2]), 32'd0);
      pin_in = 1'b0; step();
      load(0, 70);
      chk("R9 reload restores drive", 32'(pin_oe), 32'd1);
      set_bus(70, 0); step();
      set_bus(75, 0); pin_in = 1'b1; step();
      chk("R9 in-window edge keeps drive", 32'(pin_oe), 32'd1);
      chk("R9 in-window capture", 32'(cap0_val), 32'd75);
      pin_in = 1'b0; set_bus(80, 0); step();
      set_bus(85, 0); pin_in = 1'b1; step();
      chk("R9 late edge trips drive", 32'(pin_oe), 32'd0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule